// File: doc/BRIEF.md
# Paged and Indirect Data Address Generator

This block produces the 16-bit data-memory address for every operand access of a signal-processing core. Two sources share the one address output. In direct mode a 9-bit page register supplies the upper address bits and a 7-bit offset from the instruction word supplies the lower bits, which splits the 64K-word data space into 512 pages of 128 words. In indirect mode the address is the whole 16-bit content of one of eight auxiliary registers, chosen by a 3-bit pointer register.

A small arithmetic unit belongs to the auxiliary bank. On each indirect access it can rewrite the selected register after that register has supplied the address. It can step the register by one, by the value of auxiliary register 0, or by an external operand, and it can also leave the register unchanged. Decode logic around the block drives the mode, the offset, the update code and the load strobes. The address is combinational from the register state and the current inputs. Every register changes only on the rising clock edge.

Top module: `dagen_top`

## Requirements
- R1: After reset the page register, the pointer register and all eight auxiliary registers hold zero, so the address is 0 in both modes.
- R2: When `mode_ind` is 0, `addr` equals the page register in bits 15..7 and `ofs` in bits 6..0.
- R3: A page load (`pg_ld`=1) is applied at the next rising edge. The address of the cycle that carries the load still uses the old page.
- R4: When `mode_ind` is 1, `addr` equals the full 16-bit value of the auxiliary register whose index is held in the pointer register.
- R5: A pointer load (`ptr_ld`=1) during an access leaves that access using the old pointer, for both its address and its update. The new pointer applies from the next cycle.
- R6: When `acc_valid`=1 and `mode_ind`=1, the selected register is rewritten at the clock edge according to `upd_code`: 0 none, 1 add one, 2 subtract one, 3 add AR0, 4 subtract AR0. All arithmetic wraps modulo 2^16.
- R7: Auxiliary registers change only through an indirect access with `acc_valid`=1 or through their load strobes. A direct-mode access, or an indirect cycle with `acc_valid`=0, leaves them unchanged.
- R8: If `ar_ld` loads the register that is being updated in the same cycle, it takes `ar_din` and the update is dropped.
- R9: A load of a different auxiliary register in the same cycle as an update completes alongside the update.
- R10: Codes 3 and 4 use AR0 as it stood before the edge. This includes the case where AR0 is itself the selected register, so that code 3 doubles it.
- R11: Code 5 adds `opnd` to the selected register and code 6 subtracts it. Code 7 leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An operand access takes place this cycle |
| mode_ind | input | 1 | 0 = paged direct address, 1 = indirect through auxiliary register |
| ofs | input | 7 | Instruction offset within the page |
| upd_code | input | 3 | Post-access update of the selected auxiliary register |
| opnd | input | 16 | Operand for update codes 5 and 6 |
| pg_ld | input | 1 | Load strobe for the page register |
| pg_din | input | 9 | New page value |
| ptr_ld | input | 1 | Load strobe for the pointer register |
| ptr_din | input | 3 | New pointer value |
| ar_ld | input | 8 | Per-register load strobes, bit k loads register k |
| ar_din | input | 16 | Load data for the auxiliary registers |
| addr | output | 16 | Data-memory address |

## Verification
The bench puts an update on the same cycle as a pointer load. A design that used the new pointer too early would send the address or the increment to the wrong register. It loads the selected register on the same cycle as an update and expects the load to win, and it loads a neighbouring register together with an update and expects both to land. A faulty priority or a shared write port would lose one of them. It also drives the counter through 0xFFFF and 0x0000 to catch a width error, and doubles AR0 through itself to catch a design that read AR0 after the write.

// File: rtl/dagen_pkg.sv
package dagen_pkg;

    parameter int AW   = 16;
    parameter int PGW  = 9;
    parameter int NAR  = 8;
    parameter int UPDW = 3;

    localparam int OFSW = AW - PGW;
    localparam int PTRW = $clog2(NAR);

    typedef logic [AW-1:0]          word_t;
    typedef word_t [NAR-1:0]        arfile_t;

    typedef enum logic [UPDW-1:0] {
        UPD_NONE = 3'd0,
        UPD_INC  = 3'd1,
        UPD_DEC  = 3'd2,
        UPD_ADD0 = 3'd3,
        UPD_SUB0 = 3'd4,
        UPD_ADDK = 3'd5,
        UPD_SUBK = 3'd6,
        UPD_RSV  = 3'd7
    } upd_e;

    typedef struct packed {
        logic [PGW-1:0]  pg;
        logic [PTRW-1:0] ptr;
        arfile_t         ar;
    } state_t;

endpackage

// File: rtl/dagen_aux_alu.sv
module dagen_aux_alu
    import dagen_pkg::*;
(
    input  logic [UPDW-1:0] upd_code,
    input  word_t           cur,
    input  word_t           ar0,
    input  word_t           opnd,
    output word_t           nxt,
    output logic            wr
);

    upd_e code;

    always_comb begin
        code = upd_e'(upd_code);
        nxt  = cur;
        wr   = 1'b1;
        unique case (code)
            UPD_INC:  nxt = cur + word_t'(1);
            UPD_DEC:  nxt = cur - word_t'(1);
            UPD_ADD0: nxt = cur + ar0;
            UPD_SUB0: nxt = cur - ar0;
            UPD_ADDK: nxt = cur + opnd;
            UPD_SUBK: nxt = cur - opnd;
            default:  wr  = 1'b0;
        endcase
    end

endmodule

// File: rtl/dagen_regs.sv
module dagen_regs
    import dagen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pg_ld,
    input  logic [PGW-1:0]   pg_din,
    input  logic             ptr_ld,
    input  logic [PTRW-1:0]  ptr_din,
    input  logic [NAR-1:0]   ar_ld,
    input  word_t            ar_din,
    input  logic             upd_en,
    input  word_t            upd_val,
    output logic [PGW-1:0]   pg_q,
    output logic [PTRW-1:0]  ptr_q,
    output arfile_t          ar_q
);

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pg_ld)  st_d.pg  = pg_din;
        if (ptr_ld) st_d.ptr = ptr_din;
        for (int k = 0; k < NAR; k++) begin
            if (upd_en && (PTRW'(k) == st_q.ptr)) st_d.ar[k] = upd_val;
            if (ar_ld[k])                         st_d.ar[k] = ar_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pg_q  = st_q.pg;
    assign ptr_q = st_q.ptr;
    assign ar_q  = st_q.ar;

endmodule

// File: rtl/dagen_addr_sel.sv
module dagen_addr_sel
    import dagen_pkg::*;
(
    input  logic             mode_ind,
    input  logic [PGW-1:0]   pg_q,
    input  logic [OFSW-1:0]  ofs,
    input  logic [PTRW-1:0]  ptr_q,
    input  arfile_t          ar_q,
    output word_t            sel_ar,
    output word_t            addr
);

    word_t masked [NAR];

    for (genvar g = 0; g < NAR; g++) begin : g_mask
        assign masked[g] = (ptr_q == PTRW'(g)) ? ar_q[g] : '0;
    end

    always_comb begin
        sel_ar = '0;
        for (int k = 0; k < NAR; k++) sel_ar = sel_ar | masked[k];
        addr = mode_ind ? sel_ar : {pg_q, ofs};
    end

endmodule

// File: rtl/dagen_top.sv
module dagen_top
    import dagen_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    input  logic                        mode_ind,
    input  logic [dagen_pkg::OFSW-1:0]  ofs,
    input  logic [dagen_pkg::UPDW-1:0]  upd_code,
    input  logic [dagen_pkg::AW-1:0]    opnd,
    input  logic                        pg_ld,
    input  logic [dagen_pkg::PGW-1:0]   pg_din,
    input  logic                        ptr_ld,
    input  logic [dagen_pkg::PTRW-1:0]  ptr_din,
    input  logic [dagen_pkg::NAR-1:0]   ar_ld,
    input  logic [dagen_pkg::AW-1:0]    ar_din,
    output logic [dagen_pkg::AW-1:0]    addr
);

    logic [PGW-1:0]  pg_q;
    logic [PTRW-1:0] ptr_q;
    arfile_t         ar_q;
    word_t           sel_ar;
    word_t           upd_val;
    logic            alu_wr;
    logic            upd_en;

    dagen_addr_sel u_sel (
        .mode_ind (mode_ind),
        .pg_q     (pg_q),
        .ofs      (ofs),
        .ptr_q    (ptr_q),
        .ar_q     (ar_q),
        .sel_ar   (sel_ar),
        .addr     (addr)
    );

    dagen_aux_alu u_alu (
        .upd_code (upd_code),
        .cur      (sel_ar),
        .ar0      (ar_q[0]),
        .opnd     (opnd),
        .nxt      (upd_val),
        .wr       (alu_wr)
    );

    assign upd_en = acc_valid & mode_ind & alu_wr;

    dagen_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .pg_ld   (pg_ld),
        .pg_din  (pg_din),
        .ptr_ld  (ptr_ld),
        .ptr_din (ptr_din),
        .ar_ld   (ar_ld),
        .ar_din  (ar_din),
        .upd_en  (upd_en),
        .upd_val (upd_val),
        .pg_q    (pg_q),
        .ptr_q   (ptr_q),
        .ar_q    (ar_q)
    );

endmodule

// File: rtl/dagen_chk.sv
module dagen_chk
    import dagen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             mode_ind,
    input  logic [OFSW-1:0]  ofs,
    input  logic [UPDW-1:0]  upd_code,
    input  logic             pg_ld,
    input  logic [PGW-1:0]   pg_din,
    input  logic             ptr_ld,
    input  logic [PTRW-1:0]  ptr_din,
    input  logic [NAR-1:0]   ar_ld,
    input  word_t            ar_din,
    input  word_t            addr,
    input  logic [PGW-1:0]   pg_q,
    input  logic [PTRW-1:0]  ptr_q,
    input  arfile_t          ar_q
);

    logic [PTRW-1:0] ptr_last;
    word_t           sel_last;
    word_t           sel_after;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_last <= '0;
            sel_last <= '0;
        end else begin
            ptr_last <= ptr_q;
            sel_last <= ar_q[ptr_q];
        end
    end

    assign sel_after = ar_q[ptr_last];

    assert_direct_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ind |-> addr[OFSW-1:0] == ofs);

    assert_direct_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ind |-> addr[AW-1:OFSW] == pg_q);

    assert_page_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pg_ld |=> pg_q == $past(pg_din));

    assert_indirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ind |-> addr == ar_q[ptr_q]);

    assert_ptr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_ld |=> ptr_q == $past(ptr_din));

    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_ld |=> $stable(ptr_q));

    assert_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && mode_ind && upd_code == UPD_INC && !ar_ld[ptr_q])
        |=> sel_after == sel_last + word_t'(1));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(acc_valid && mode_ind) && ar_ld == '0) |=> $stable(ar_q));

    for (genvar g = 0; g < NAR; g++) begin : g_ld
        assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ar_ld[g] |=> ar_q[g] == $past(ar_din));
    end

endmodule

bind dagen_top dagen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .mode_ind  (mode_ind),
    .ofs       (ofs),
    .upd_code  (upd_code),
    .pg_ld     (pg_ld),
    .pg_din    (pg_din),
    .ptr_ld    (ptr_ld),
    .ptr_din   (ptr_din),
    .ar_ld     (ar_ld),
    .ar_din    (ar_din),
    .addr      (addr),
    .pg_q      (pg_q),
    .ptr_q     (ptr_q),
    .ar_q      (ar_q)
);

// File: tb/dagen_top_tb.sv
module dagen_top_tb;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, mode_ind, pg_ld, ptr_ld;
    logic [6:0]  ofs;
    logic [2:0]  upd_code, ptr_din;
    logic [15:0] opnd, ar_din, addr;
    logic [8:0]  pg_din;
    logic [7:0]  ar_ld;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [8:0]  m_pg;
    logic [2:0]  m_ptr;
    logic [15:0] m_ar [8];

    always #(CLK_NS/2) clk = ~clk;

    dagen_top u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .mode_ind(mode_ind),
        .ofs(ofs), .upd_code(upd_code), .opnd(opnd), .pg_ld(pg_ld),
        .pg_din(pg_din), .ptr_ld(ptr_ld), .ptr_din(ptr_din), .ar_ld(ar_ld),
        .ar_din(ar_din), .addr(addr)
    );

    function automatic logic [15:0] model_addr();
        return mode_ind ? m_ar[m_ptr] : {m_pg, ofs};
    endfunction

    task automatic model_clock();
        logic [15:0] cur, a0, nv;
        bit          wr;
        cur = m_ar[m_ptr];
        a0  = m_ar[0];
        wr  = 1;
        case (upd_code)
            3'd1: nv = cur + 16'd1;
            3'd2: nv = cur - 16'd1;
            3'd3: nv = cur + a0;
            3'd4: nv = cur - a0;
            3'd5: nv = cur + opnd;
            3'd6: nv = cur - opnd;
            default: begin nv = cur; wr = 0; end
        endcase
        if (acc_valid && mode_ind && wr) m_ar[m_ptr] = nv;
        for (int k = 0; k < 8; k++) if (ar_ld[k]) m_ar[k] = ar_din;
        if (pg_ld)  m_pg  = pg_din;
        if (ptr_ld) m_ptr = ptr_din;
    endtask

    task automatic clr();
        acc_valid = 0; mode_ind = 0; ofs = '0; upd_code = '0; opnd = '0;
        pg_ld = 0; pg_din = '0; ptr_ld = 0; ptr_din = '0; ar_ld = '0; ar_din = '0;
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr got %h expected %h", req, got, exp);
        end
    endtask

    // one access cycle: inputs set after a falling edge, checked, then clocked
    task automatic step(input string req);
        #2;
        check(req, addr, model_addr());
        @(posedge clk);
        model_clock();
        @(negedge clk);
    endtask

    task automatic look(input string req, input logic [2:0] p);
        clr(); ptr_ld = 1; ptr_din = p; step(req);
        clr(); mode_ind = 1; step(req);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        clr();
        rst_n = 0;
        m_pg = '0; m_ptr = '0;
        for (int k = 0; k < 8; k++) m_ar[k] = '0;
        #(CLK_NS * 3);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state in both modes
        clr(); step("R1");
        clr(); mode_ind = 1; step("R1");

        // R3 page load is seen one cycle later
        clr(); pg_ld = 1; pg_din = 9'h1A5; ofs = 7'h33; step("R3");
        clr(); ofs = 7'h33; step("R3");
        // R2 extremes of page and offset
        clr(); pg_ld = 1; pg_din = 9'h1FF; step("R2");
        clr(); ofs = 7'h7F; step("R2");
        clr(); ofs = 7'h00; step("R2");

        // R4 load and read back every register
        for (int k = 0; k < 8; k++) begin
            clr(); ar_ld[k] = 1; ar_din = 16'h1111 * 16'(k) + 16'h0100; step("R4");
        end
        for (int k = 0; k < 8; k++) look("R4", 3'(k));

        // R5 pointer load during an update: old pointer used
        look("R5", 3'd2);
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd1;
        ptr_ld = 1; ptr_din = 3'd5; step("R5");
        clr(); mode_ind = 1; step("R5");
        look("R5", 3'd2);

        // R6 each code, with wraparound
        clr(); ar_ld[5] = 1; ar_din = 16'hFFFF; step("R6");
        look("R6", 3'd5);
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd1; step("R6");
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd2; step("R6");
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd2; step("R6");
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd3; step("R6");
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd4; step("R6");
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd0; step("R6");
        clr(); mode_ind = 1; step("R6");

        // R10 AR0 through itself
        look("R10", 3'd0);
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd3; step("R10");
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd4; step("R10");
        clr(); mode_ind = 1; step("R10");

        // R8 load beats update on the same register
        look("R8", 3'd6);
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd1;
        ar_ld[6] = 1; ar_din = 16'hBEEF; step("R8");
        clr(); mode_ind = 1; step("R8");

        // R9 load of another register alongside an update
        look("R9", 3'd3);
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd2;
        ar_ld[4] = 1; ar_din = 16'h0042; step("R9");
        clr(); mode_ind = 1; step("R9");
        look("R9", 3'd4);

        // R7 no update outside an indirect access
        look("R7", 3'd1);
        clr(); acc_valid = 1; upd_code = 3'd1; ofs = 7'h11; step("R7");
        clr(); mode_ind = 1; upd_code = 3'd3; step("R7");
        clr(); mode_ind = 1; step("R7");

        // R11 operand add/subtract and reserved code
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd5; opnd = 16'hF00F; step("R11");
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd6; opnd = 16'h1234; step("R11");
        clr(); mode_ind = 1; acc_valid = 1; upd_code = 3'd7; opnd = 16'h7777; step("R11");
        clr(); mode_ind = 1; step("R11");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            clr();
            mode_ind  = $urandom_range(0, 2) != 0;
            acc_valid = $urandom_range(0, 3) != 0;
            upd_code  = 3'($urandom_range(0, 7));
            ofs       = 7'($urandom);
            opnd      = 16'($urandom);
            pg_ld     = $urandom_range(0, 7) == 0;
            pg_din    = 9'($urandom);
            ptr_ld    = $urandom_range(0, 3) == 0;
            ptr_din   = 3'($urandom);
            ar_din    = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
            if ($urandom_range(0, 5) == 0) ar_ld = 8'(1 << $urandom_range(0, 7));
            if (mode_ind) step("R4"); else step("R2");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule